// File: doc/BRIEF.md
# Sleep, Wake-Up and Reset-Cause Controller

This block tracks whether the device is powered down and records why the device was last reset. A sleep command stops the oscillator and pulses a watchdog clear. Every way out of sleep is turned into a device reset. Those ways are the external reset pin, a watchdog timeout, a change on the monitored input pins and a change of the comparator output. Four status bits (timeout, power-down, pin-wake flag, comparator-wake flag) let software tell the causes apart once it runs again.

After power-up, and after any reset trigger, a device-reset timer holds the reset output high for a parameterised number of clock cycles. With the crystal variant the full delay follows every trigger. With the RC variant the full delay follows power-up only, and other triggers give a one-cycle reset. Pin-change detection compares the live pins with a copy taken on the sleep-entry edge. The comparator input is handled the same way. The oscillator and the watchdog counter live outside the block.

All inputs are sampled on the rising clock edge. Every output is a register, so it changes on the edge that samples the stimulus. `por_n` is the asynchronous power-on reset.

Top module: `pwr_wake_ctl`

## Requirements
- R1: While `por_n` is low: `st_to`=1, `st_pd`=1, `st_pwf`=0, `st_cwf`=0, `osc_off`=0 and `dev_rst`=1. After `por_n` rises, `dev_rst` stays 1 for exactly DRT_CYCLES rising edges and then falls.
- R2: When `sleep_cmd` is sampled high while awake and out of reset, the same edge sets `osc_off`=1, `st_to`=1 and `st_pd`=0, and pulses `wdt_clr` high for one cycle.
- R3: `sleep_cmd` has no effect while `dev_rst` is high.
- R4: A `wdt_timeout` sampled with `wdt_en`=1 while awake starts a device reset. It sets `st_to`=0, clears both wake flags and leaves `st_pd` unchanged.
- R5: With `wdt_en`=0, `wdt_timeout` has no effect on reset, sleep or status.
- R6: In sleep with `pin_wake_en`=1, any monitored pin that differs from its value on the sleep-entry edge ends sleep with a device reset. The status becomes `st_to`=1, `st_pd`=0, `st_pwf`=1, `st_cwf`=0. With `pin_wake_en`=0, pin changes do not wake.
- R7: In sleep with `cmp_wake_en`=1, a comparator value that differs from its sleep-entry value wakes the device with `st_cwf`=1 and `st_pwf`=0. With `cmp_wake_en`=0 it does not wake. If a pin change and a comparator change are sampled together, both flags are set.
- R8: While `ext_rst_n` is low, `dev_rst` is held high and both wake flags are cleared. `st_to` and `st_pd` are kept. A low `ext_rst_n` takes priority over a wake event sampled on the same edge, so no wake flag is set.
- R9: In the crystal variant, `dev_rst` is high for DRT_CYCLES samples, counted from the last edge that saw a trigger. In the RC variant, triggers other than power-up give a single high sample.
- R10: A `wdt_timeout` with `wdt_en`=1 during sleep wakes the device with a reset and status `st_to`=0, `st_pd`=0, no wake flags.
- R11: Pin and comparator changes while awake cause no reset and set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_n | input | 1 | External reset pin, active low, sampled synchronously |
| sleep_cmd | input | 1 | Request to enter sleep |
| wdt_en | input | 1 | Watchdog enable configuration bit |
| wdt_timeout | input | 1 | Watchdog timeout pulse |
| pin_wake_en | input | 1 | Enables wake on pin change |
| pins_in | input | PIN_W | Monitored input pins |
| cmp_wake_en | input | 1 | Enables wake on comparator change |
| cmp_in | input | 1 | Comparator output |
| osc_off | output | 1 | High while asleep; stops the oscillator and freezes I/O |
| wdt_clr | output | 1 | One-cycle watchdog clear on sleep entry |
| dev_rst | output | 1 | Device reset, held for the reset-timer delay |
| st_to | output | 1 | Timeout status; 0 after a watchdog reset |
| st_pd | output | 1 | Power-down status; 1 from power-up, 0 after sleep |
| st_pwf | output | 1 | Pin-change wake flag |
| st_cwf | output | 1 | Comparator-change wake flag |

## Verification
A stale sleep-entry snapshot would show at the ports as a spurious or missing wake. `osc_off` falls and `dev_rst` rises on the very edge that samples the pin or comparator. A wrong priority among simultaneous causes would leave a wrong status bit pattern on the trigger edge. A wrong reload value in the reset timer only shows when `dev_rst` falls, up to DRT_CYCLES edges later, so the bench counts every high sample of `dev_rst` after each trigger.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;
   typedef struct packed {
      logic to;
      logic pd;
      logic pwf;
      logic cwf;
   } cause_t;

   localparam cause_t CAUSE_POR = '{to: 1'b1, pd: 1'b1, pwf: 1'b0, cwf: 1'b0};
endpackage

// File: rtl/pwr_wake_det.sv
module pwr_wake_det #(
   parameter int PIN_W = 3
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             capture,
   input  logic             armed,
   input  logic             pin_en,
   input  logic [PIN_W-1:0] pins,
   input  logic             cmp_en,
   input  logic             cmp,
   output logic             pin_hit,
   output logic             cmp_hit
);
   logic [PIN_W-1:0] snap_pins;
   logic             snap_cmp;
   logic [PIN_W-1:0] diff;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         snap_pins <= '0;
         snap_cmp  <= 1'b0;
      end else if (capture) begin
         snap_pins <= pins;
         snap_cmp  <= cmp;
      end
   end

   for (genvar i = 0; i < PIN_W; i++) begin : g_cmp_bit
      assign diff[i] = pins[i] ^ snap_pins[i];
   end

   assign pin_hit = armed & pin_en & (|diff);
   assign cmp_hit = armed & cmp_en & (cmp ^ snap_cmp);
endmodule

// File: rtl/pwr_drt.sv
module pwr_drt #(
   parameter int DRT_CYCLES  = 64,
   parameter bit OSC_CRYSTAL = 1'b1
) (
   input  logic clk,
   input  logic por_n,
   input  logic load,
   output logic busy
);
   localparam int CNT_W = $clog2(DRT_CYCLES + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DRT_CYCLES);

   logic [CNT_W-1:0] reload;
   logic [CNT_W-1:0] cnt;

   if (OSC_CRYSTAL) begin : g_xtal
      assign reload = FULL;
   end else begin : g_rc
      assign reload = CNT_W'(1);
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         cnt <= FULL;
      else if (load)
         cnt <= reload;
      else if (cnt != '0)
         cnt <= cnt - CNT_W'(1);
   end

   assign busy = (cnt != '0);
endmodule

// File: rtl/pwr_cause.sv
module pwr_cause
   import pwr_wake_pkg::*;
(
   input  logic   clk,
   input  logic   por_n,
   input  logic   ev_ext,
   input  logic   ev_wdt,
   input  logic   ev_pin,
   input  logic   ev_cmp,
   input  logic   ev_sleep,
   output cause_t cause
);
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cause <= CAUSE_POR;
      end else if (ev_ext) begin
         cause.pwf <= 1'b0;
         cause.cwf <= 1'b0;
      end else if (ev_wdt) begin
         cause.to  <= 1'b0;
         cause.pwf <= 1'b0;
         cause.cwf <= 1'b0;
      end else if (ev_pin || ev_cmp) begin
         cause.pwf <= ev_pin;
         cause.cwf <= ev_cmp;
      end else if (ev_sleep) begin
         cause.to <= 1'b1;
         cause.pd <= 1'b0;
      end
   end
endmodule

// File: rtl/pwr_wake_ctl.sv
module pwr_wake_ctl
   import pwr_wake_pkg::*;
#(
   parameter int PIN_W       = 3,
   parameter int DRT_CYCLES  = 64,
   parameter bit OSC_CRYSTAL = 1'b1
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             ext_rst_n,
   input  logic             sleep_cmd,
   input  logic             wdt_en,
   input  logic             wdt_timeout,
   input  logic             pin_wake_en,
   input  logic [PIN_W-1:0] pins_in,
   input  logic             cmp_wake_en,
   input  logic             cmp_in,
   output logic             osc_off,
   output logic             wdt_clr,
   output logic             dev_rst,
   output logic             st_to,
   output logic             st_pd,
   output logic             st_pwf,
   output logic             st_cwf
);
   if (PIN_W < 1) begin : g_bad_pin_w
      $error("pwr_wake_ctl: PIN_W must be at least 1");
   end
   if (DRT_CYCLES < 1) begin : g_bad_drt
      $error("pwr_wake_ctl: DRT_CYCLES must be at least 1");
   end

   logic   sleep_q, clr_q;
   logic   ev_ext, ev_wdt, ev_pin, ev_cmp, ev_sleep, trig;
   cause_t cause;

   assign ev_ext   = ~ext_rst_n;
   assign ev_wdt   = wdt_en & wdt_timeout;
   assign ev_sleep = sleep_cmd & ~sleep_q & ~dev_rst & ~ev_ext & ~ev_wdt;
   assign trig     = ev_ext | ev_wdt | ev_pin | ev_cmp;

   pwr_wake_det #(.PIN_W(PIN_W)) u_det (
      .clk     (clk),
      .por_n   (por_n),
      .capture (ev_sleep),
      .armed   (sleep_q),
      .pin_en  (pin_wake_en),
      .pins    (pins_in),
      .cmp_en  (cmp_wake_en),
      .cmp     (cmp_in),
      .pin_hit (ev_pin),
      .cmp_hit (ev_cmp)
   );

   pwr_drt #(.DRT_CYCLES(DRT_CYCLES), .OSC_CRYSTAL(OSC_CRYSTAL)) u_drt (
      .clk   (clk),
      .por_n (por_n),
      .load  (trig),
      .busy  (dev_rst)
   );

   pwr_cause u_cause (
      .clk      (clk),
      .por_n    (por_n),
      .ev_ext   (ev_ext),
      .ev_wdt   (ev_wdt),
      .ev_pin   (ev_pin),
      .ev_cmp   (ev_cmp),
      .ev_sleep (ev_sleep),
      .cause    (cause)
   );

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         sleep_q <= 1'b0;
         clr_q   <= 1'b0;
      end else begin
         clr_q <= ev_sleep;
         if (trig)
            sleep_q <= 1'b0;
         else if (ev_sleep)
            sleep_q <= 1'b1;
      end
   end

   assign osc_off = sleep_q;
   assign wdt_clr = clr_q;
   assign st_to   = cause.to;
   assign st_pd   = cause.pd;
   assign st_pwf  = cause.pwf;
   assign st_cwf  = cause.cwf;
endmodule

// File: rtl/pwr_wake_chk.sv
module pwr_wake_chk #(
   parameter int PIN_W = 3
) (
   input logic             clk,
   input logic             por_n,
   input logic             ext_rst_n,
   input logic             sleep_cmd,
   input logic             wdt_en,
   input logic             wdt_timeout,
   input logic             pin_wake_en,
   input logic [PIN_W-1:0] pins_in,
   input logic             cmp_wake_en,
   input logic             cmp_in,
   input logic             osc_off,
   input logic             wdt_clr,
   input logic             dev_rst,
   input logic             st_to,
   input logic             st_pd,
   input logic             st_pwf,
   input logic             st_cwf
);
   p_sleep_entry_r2: assert property (@(posedge clk) disable iff (!por_n)
      $rose(osc_off) |-> (st_to && !st_pd && wdt_clr));

   p_no_sleep_in_reset_r3: assert property (@(posedge clk) disable iff (!por_n)
      osc_off |-> !dev_rst);

   p_wdt_reset_r4: assert property (@(posedge clk) disable iff (!por_n)
      (wdt_en && wdt_timeout && ext_rst_n) |=> (dev_rst && !st_to && !osc_off));

   p_wdt_masked_r5: assert property (@(posedge clk) disable iff (!por_n)
      (!wdt_en && wdt_timeout && ext_rst_n && !osc_off && !sleep_cmd)
      |=> (st_to == $past(st_to) && st_pd == $past(st_pd)));

   p_wake_is_reset_r6: assert property (@(posedge clk) disable iff (!por_n)
      $fell(osc_off) |-> dev_rst);

   p_flags_after_sleep_r7: assert property (@(posedge clk) disable iff (!por_n)
      (st_pwf || st_cwf) |-> !st_pd);

   p_ext_hold_r8: assert property (@(posedge clk) disable iff (!por_n)
      !ext_rst_n |=> (dev_rst && !st_pwf && !st_cwf && !osc_off));
endmodule

bind pwr_wake_ctl pwr_wake_chk #(.PIN_W(PIN_W)) u_chk (
   .clk         (clk),
   .por_n       (por_n),
   .ext_rst_n   (ext_rst_n),
   .sleep_cmd   (sleep_cmd),
   .wdt_en      (wdt_en),
   .wdt_timeout (wdt_timeout),
   .pin_wake_en (pin_wake_en),
   .pins_in     (pins_in),
   .cmp_wake_en (cmp_wake_en),
   .cmp_in      (cmp_in),
   .osc_off     (osc_off),
   .wdt_clr     (wdt_clr),
   .dev_rst     (dev_rst),
   .st_to       (st_to),
   .st_pd       (st_pd),
   .st_pwf      (st_pwf),
   .st_cwf      (st_cwf)
);

// File: tb/sim_pwr_wake_ctl.sv
`timescale 1ns/100ps
module sim_pwr_wake_ctl;
   localparam int PW  = 3;
   localparam int DRT = 16;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          por_n, ext_rst_n, sleep_cmd, wdt_en, wdt_timeout;
   logic          pin_wake_en, cmp_wake_en, cmp_in;
   logic [PW-1:0] pins_in;
   logic osc_off, wdt_clr, dev_rst, st_to, st_pd, st_pwf, st_cwf;
   logic r_osc_off, r_wdt_clr, r_dev_rst, r_to, r_pd, r_pwf, r_cwf;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   pwr_wake_ctl #(.PIN_W(PW), .DRT_CYCLES(DRT), .OSC_CRYSTAL(1'b1)) u0 (
      .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .sleep_cmd(sleep_cmd),
      .wdt_en(wdt_en), .wdt_timeout(wdt_timeout), .pin_wake_en(pin_wake_en),
      .pins_in(pins_in), .cmp_wake_en(cmp_wake_en), .cmp_in(cmp_in),
      .osc_off(osc_off), .wdt_clr(wdt_clr), .dev_rst(dev_rst), .st_to(st_to),
      .st_pd(st_pd), .st_pwf(st_pwf), .st_cwf(st_cwf));

   pwr_wake_ctl #(.PIN_W(PW), .DRT_CYCLES(DRT), .OSC_CRYSTAL(1'b0)) u1 (
      .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .sleep_cmd(sleep_cmd),
      .wdt_en(wdt_en), .wdt_timeout(wdt_timeout), .pin_wake_en(pin_wake_en),
      .pins_in(pins_in), .cmp_wake_en(cmp_wake_en), .cmp_in(cmp_in),
      .osc_off(r_osc_off), .wdt_clr(r_wdt_clr), .dev_rst(r_dev_rst), .st_to(r_to),
      .st_pd(r_pd), .st_pwf(r_pwf), .st_cwf(r_cwf));

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic chk_st(input string tag, input int to, input int pd, input int pwf, input int cwf);
      chk({tag, " st_to"},  int'(st_to),  to);
      chk({tag, " st_pd"},  int'(st_pd),  pd);
      chk({tag, " st_pwf"}, int'(st_pwf), pwf);
      chk({tag, " st_cwf"}, int'(st_cwf), cwf);
   endtask

   task automatic step(input int n = 1);
      repeat (n) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   // counts high samples of dev_rst, the current one included
   task automatic count_rst(input string tag, input int exp);
      int k = 0;
      while (dev_rst === 1'b1 && k < 1000) begin
         k++;
         step();
      end
      chk(tag, k, exp);
   endtask

   task automatic enter_sleep(input string tag);
      sleep_cmd = 1'b1;
      step();
      sleep_cmd = 1'b0;
      chk({tag, " R2 osc_off"}, int'(osc_off), 1);
      chk({tag, " R2 wdt_clr"}, int'(wdt_clr), 1);
      chk_st({tag, " R2"}, 1, 0, int'(st_pwf), int'(st_cwf));
      step();
      chk({tag, " R2 wdt_clr pulse"}, int'(wdt_clr), 0);
      chk({tag, " R2 still asleep"}, int'(osc_off), 1);
   endtask

   task automatic t_powerup();
      step(3);
      chk_st("R1 reset", 1, 1, 0, 0);
      chk("R1 osc_off", int'(osc_off), 0);
      chk("R1 dev_rst", int'(dev_rst), 1);
      por_n = 1'b1;
      sleep_cmd = 1'b1;
      step();
      sleep_cmd = 1'b0;
      chk("R3 sleep ignored in reset", int'(osc_off), 0);
      chk("R9 rc power-up hold", int'(r_dev_rst), 1);
      count_rst("R1 power-up delay", DRT - 1);
      chk("R9 rc power-up released", int'(r_dev_rst), 0);
      chk("R3 still awake", int'(osc_off), 0);
   endtask

   task automatic t_awake_changes();
      pin_wake_en = 1'b1;
      cmp_wake_en = 1'b1;
      pins_in = 3'b010;
      cmp_in = 1'b1;
      step(2);
      chk("R11 no reset", int'(dev_rst), 0);
      chk_st("R11", 1, 1, 0, 0);
      chk("R11 awake", int'(osc_off), 0);
   endtask

   task automatic t_wdt_masked();
      wdt_en = 1'b0;
      wdt_timeout = 1'b1;
      step();
      wdt_timeout = 1'b0;
      chk("R5 no reset", int'(dev_rst), 0);
      chk_st("R5", 1, 1, 0, 0);
   endtask

   task automatic t_wdt_run();
      wdt_en = 1'b1;
      wdt_timeout = 1'b1;
      step();
      wdt_timeout = 1'b0;
      chk("R4 dev_rst", int'(dev_rst), 1);
      chk_st("R4", 0, 1, 0, 0);
      count_rst("R9 wdt delay", DRT);
   endtask

   task automatic t_wake_pin();
      pin_wake_en = 1'b1;
      cmp_wake_en = 1'b0;
      enter_sleep("pin");
      step(3);
      chk("R6 no change stays asleep", int'(osc_off), 1);
      cmp_in = ~cmp_in;
      step(2);
      chk("R7 cmp disabled stays asleep", int'(osc_off), 1);
      pins_in[1] = ~pins_in[1];
      step();
      chk("R6 woke", int'(osc_off), 0);
      chk("R6 dev_rst", int'(dev_rst), 1);
      chk_st("R6", 1, 0, 1, 0);
      chk("R9 rc wake pulse", int'(r_dev_rst), 1);
      step();
      chk("R9 rc one cycle", int'(r_dev_rst), 0);
      count_rst("R9 pin wake delay", DRT - 1);
   endtask

   task automatic t_wake_cmp();
      pin_wake_en = 1'b0;
      cmp_wake_en = 1'b1;
      enter_sleep("cmp");
      pins_in[0] = ~pins_in[0];
      step(2);
      chk("R6 pin disabled stays asleep", int'(osc_off), 1);
      cmp_in = ~cmp_in;
      step();
      chk("R7 woke", int'(osc_off), 0);
      chk_st("R7", 1, 0, 0, 1);
      count_rst("R9 cmp wake delay", DRT);
   endtask

   task automatic t_wake_both();
      pin_wake_en = 1'b1;
      cmp_wake_en = 1'b1;
      enter_sleep("both");
      pins_in[2] = ~pins_in[2];
      cmp_in = ~cmp_in;
      step();
      chk("R7 both woke", int'(osc_off), 0);
      chk_st("R7 both", 1, 0, 1, 1);
      count_rst("R9 both delay", DRT);
   endtask

   task automatic t_ext();
      ext_rst_n = 1'b0;
      step();
      chk("R8 dev_rst", int'(dev_rst), 1);
      chk_st("R8 running", 1, 0, 0, 0);
      step(3);
      chk("R8 held", int'(dev_rst), 1);
      ext_rst_n = 1'b1;
      count_rst("R8 release delay", DRT);
      pin_wake_en = 1'b1;
      enter_sleep("ext");
      ext_rst_n = 1'b0;
      pins_in[0] = ~pins_in[0];
      step();
      ext_rst_n = 1'b1;
      chk("R8 priority woke", int'(osc_off), 0);
      chk("R8 priority dev_rst", int'(dev_rst), 1);
      chk_st("R8 priority", 1, 0, 0, 0);
      count_rst("R8 priority delay", DRT);
   endtask

   task automatic t_wdt_sleep();
      wdt_en = 1'b1;
      enter_sleep("wdt");
      wdt_timeout = 1'b1;
      step();
      wdt_timeout = 1'b0;
      chk("R10 woke", int'(osc_off), 0);
      chk("R10 dev_rst", int'(dev_rst), 1);
      chk_st("R10", 0, 0, 0, 0);
      count_rst("R10 delay", DRT);
   endtask

   initial begin
      por_n = 1'b0;
      ext_rst_n = 1'b1;
      sleep_cmd = 1'b0;
      wdt_en = 1'b0;
      wdt_timeout = 1'b0;
      pin_wake_en = 1'b0;
      cmp_wake_en = 1'b0;
      pins_in = 3'b101;
      cmp_in = 1'b0;
      @(negedge clk);
      t_powerup();
      t_awake_changes();
      t_wdt_masked();
      t_wdt_run();
      t_wake_pin();
      t_wake_cmp();
      t_wake_both();
      t_ext();
      t_wdt_sleep();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #500000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule